// File: doc/BRIEF.md
# Calendar Real-Time Clock Core

This block holds the time of day and the calendar date in a small bank of byte registers. A host reads and writes these registers through a request/response port. A strobe input, `ref_en`, pulses once per cycle of a 32.768 kHz reference as seen in the system clock domain. An internal divider turns these pulses into a one-second tick. On each tick the seconds advance by one. A rollover carries through minutes, hours, date and day of week, month and year, all within the same clock cycle.

The bytes are stored either as BCD or as plain binary, chosen by a control bit. Hours follow a 24-hour or a 12-hour format. In 12-hour format the top bit of the hours byte marks PM. The host sets a freeze bit while it loads a new time. Three alarm bytes (seconds, minutes and hours) are compared with the freshly advanced time on every tick. An alarm byte whose two top bits are both set matches any value.

The request port never applies back-pressure: `req_ready` is always high. Every accepted read produces exactly one response on the next cycle, and `rsp_valid` has no ready signal. Writes take effect at the clock edge on which they are accepted. Any byte can be accessed at any moment, including the very cycle of a tick.

Top module: `rtc_calendar_core`

## Requirements
- R1: The one-second tick fires on every DIV-th `ref_en` pulse. Each tick advances the time by one second. Without a tick, no time byte changes except through a host write.
- R2: Seconds and minutes count 0..59 and wrap to 0, carrying into the next field. Control bit 1 selects the encoding: 0 means BCD (59 is 0x59) and 1 means binary (59 is 0x3B).
- R3: While control bit 0 (freeze) is 1, ticks leave every time and calendar byte unchanged. The divider keeps counting `ref_en` pulses while frozen.
- R4: When control bit 2 is 0 (12-hour format), bit 7 of the hours byte is PM and the hour runs 12, 1, ..., 11. The change from 11 to 12 flips PM (11 AM becomes 0x92 in BCD). The change from 11 PM to 12 AM (0x12) advances the date.
- R5: When control bit 2 is 1 (24-hour format), the hour runs 0..23, and 23 wraps to 0 with a carry into the date.
- R6: Day of week (1 = Sunday) advances only at midnight, from 1 to 7 and then back to 1.
- R7: The date wraps to 1 after the last day of the month: 30 days for months 4, 6, 9 and 11, 31 days for the other months, and 29 days for month 2 when year mod 4 = 0, otherwise 28.
- R8: After the last day of month 12 the month returns to 1 and the year advances, with 99 wrapping to 00.
- R9: A tick that advances the time sets `alarm_o` (also read back as control bit 3) when the advanced seconds, minutes and hours each equal their alarm bytes. An alarm byte with bits 7:6 = 11 matches anything. The flag holds until the next tick. A tick suppressed by freeze clears it.
- R10: `req_ready` is always 1. A read accepted at one edge gives `rsp_valid` = 1 and the byte on `rsp_data` after the next edge. `rsp_valid` is 0 otherwise. The address map is: 0 seconds, 1 alarm seconds, 2 minutes, 3 alarm minutes, 4 hours, 5 alarm hours, 6 day of week, 7 date, 8 month, 9 year, 10 control. Other addresses read 0 and ignore writes.
- R11: A write that lands in the same cycle as a tick sets the written byte to the host value. The other bytes still advance, including carries out of the overwritten field.
- R12: After reset the time is 00:00:00 in 24-hour BCD with freeze off, day of week 1, date 1, month 1 and year 00. The alarm bytes are 0 and `alarm_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_en | input | 1 | One pulse per cycle of the 32.768 kHz reference |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Always 1; requests are never stalled |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Register address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_data | output | 8 | Read data |
| alarm_o | output | 1 | Alarm match flag, held for one tick |

## Verification
The bench sweeps every hour value in both hour formats and both encodings. It walks every month end of leap and non-leap years, including the 99-to-00 year wrap, and counts seconds through two minute carries. A core that mishandles the 12-hour wrap would give 0x00 or 0x13 where 0x12 or 0x92 is due. A wrong month-length table would land on day 29, 31 or 32 where day 1 is expected. The bench also ends a divider count while freeze is set, to catch a divider that resets or stalls during freeze. It places a write exactly on a tick edge, where a core that lets the tick win would lose the host value. It checks an alarm with don't-care bytes, where a core that compares those bytes literally would never raise the flag.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W = 4;
  localparam int BYTE_W = 8;
  localparam int N_ALM  = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_SEC = 4'd0, A_ASEC = 4'd1, A_MIN = 4'd2, A_AMIN = 4'd3,
    A_HOUR = 4'd4, A_AHOUR = 4'd5, A_DOW = 4'd6, A_DATE = 4'd7,
    A_MON = 4'd8, A_YEAR = 4'd9, A_CTRL = 4'd10
  } reg_addr_e;

  typedef struct packed {
    logic [BYTE_W-1:0] year, mon, date, dow, hour, min, sec;
  } cal_t;

  // stored byte -> numeric value
  function automatic logic [6:0] dec_byte(input logic [7:0] b, input logic bin);
    logic [6:0] hi, lo;
    hi = {3'b000, b[7:4]};
    lo = {3'b000, b[3:0]};
    return bin ? b[6:0] : (hi * 7'd10 + lo);
  endfunction

  // numeric value -> stored byte
  function automatic logic [7:0] enc_byte(input logic [6:0] v, input logic bin);
    return bin ? {1'b0, v} : {4'(v / 7'd10), 4'(v % 7'd10)};
  endfunction

  // hours byte -> 0..23
  function automatic logic [4:0] hour_dec(input logic [7:0] b, input logic bin,
                                          input logic h24);
    logic [6:0] h;
    if (h24) return 5'(dec_byte(b, bin));
    h = dec_byte({1'b0, b[6:0]}, bin);
    if (h == 7'd12) h = 7'd0;
    return 5'(h) + (b[7] ? 5'd12 : 5'd0);
  endfunction

  // 0..23 -> hours byte
  function automatic logic [7:0] hour_enc(input logic [4:0] v, input logic bin,
                                          input logic h24);
    logic [6:0] r;
    logic       pm;
    if (h24) return enc_byte({2'b00, v}, bin);
    pm = (v >= 5'd12);
    r  = {2'b00, pm ? v - 5'd12 : v};
    if (r == 7'd0) r = 7'd12;
    return {pm, 7'b0} | enc_byte(r, bin);
  endfunction

  function automatic logic [6:0] days_in(input logic [6:0] mo, input logic [6:0] y);
    case (mo)
      7'd2:                     return (y % 7'd4 == 7'd0) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:  return 7'd30;
      default:                  return 7'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_en,
  output logic sec_tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign sec_tick = ref_en && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (sec_tick) cnt_q <= '0;
    else if (ref_en)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rtc_advance.sv
module rtc_advance
  import rtc_pkg::*;
(
  input  cal_t cur,
  input  logic bin,
  input  logic h24,
  output cal_t nxt
);
  logic [6:0] s, m, dw, dt, mo, y, dim;
  logic [4:0] h;
  logic       s_wr, m_wr, h_wr, dt_wr, mo_wr;

  always_comb begin
    s   = dec_byte(cur.sec, bin);
    m   = dec_byte(cur.min, bin);
    h   = hour_dec(cur.hour, bin, h24);
    dw  = dec_byte(cur.dow, bin);
    dt  = dec_byte(cur.date, bin);
    mo  = dec_byte(cur.mon, bin);
    y   = dec_byte(cur.year, bin);
    dim = days_in(mo, y);

    s_wr  = (s >= 7'd59);
    m_wr  = s_wr && (m >= 7'd59);
    h_wr  = m_wr && (h >= 5'd23);
    dt_wr = h_wr && (dt >= dim);
    mo_wr = dt_wr && (mo >= 7'd12);

    nxt      = cur;
    nxt.sec  = enc_byte(s_wr ? 7'd0 : s + 7'd1, bin);
    if (s_wr)  nxt.min  = enc_byte((m >= 7'd59) ? 7'd0 : m + 7'd1, bin);
    if (m_wr)  nxt.hour = hour_enc((h >= 5'd23) ? 5'd0 : h + 5'd1, bin, h24);
    if (h_wr) begin
      nxt.date = enc_byte((dt >= dim) ? 7'd1 : dt + 7'd1, bin);
      nxt.dow  = enc_byte((dw >= 7'd7) ? 7'd1 : dw + 7'd1, bin);
    end
    if (dt_wr) nxt.mon  = enc_byte((mo >= 7'd12) ? 7'd1 : mo + 7'd1, bin);
    if (mo_wr) nxt.year = enc_byte((y >= 7'd99) ? 7'd0 : y + 7'd1, bin);
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int N = 3
) (
  input  logic [N-1:0][7:0] now_b,
  input  logic [N-1:0][7:0] alm_b,
  output logic              hit
);
  logic [N-1:0] fld_ok;

  for (genvar i = 0; i < N; i++) begin : g_fld
    assign fld_ok[i] = (alm_b[i][7:6] == 2'b11) || (alm_b[i] == now_b[i]);
  end

  assign hit = &fld_ok;
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_pkg::*;
#(
  parameter int DIV = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BYTE_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [BYTE_W-1:0] rsp_data,
  output logic              alarm_o
);
  localparam cal_t RST_CAL = '{year: 8'h00, mon: 8'h01, date: 8'h01, dow: 8'h01,
                               hour: 8'h00, min: 8'h00, sec: 8'h00};

  cal_t                          cal_q, cal_nxt;
  logic [N_ALM-1:0][BYTE_W-1:0]  alm_q;
  logic                          set_q, bin_q, h24_q;
  logic                          sec_tick, hit;
  logic                          wr_en, rd_en;
  logic [BYTE_W-1:0]             rd_mux;

  assign req_ready = 1'b1;
  assign wr_en     = req_valid && req_write;
  assign rd_en     = req_valid && !req_write;
  assign alarm_o   = alarm_q;

  logic alarm_q;

  rtc_prescaler #(.DIV(DIV)) u_presc (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .sec_tick(sec_tick)
  );

  rtc_advance u_adv (.cur(cal_q), .bin(bin_q), .h24(h24_q), .nxt(cal_nxt));

  rtc_alarm_cmp #(.N(N_ALM)) u_alm (
    .now_b({cal_nxt.hour, cal_nxt.min, cal_nxt.sec}),
    .alm_b(alm_q),
    .hit(hit)
  );

  always_comb begin
    case (req_addr)
      A_SEC:   rd_mux = cal_q.sec;
      A_ASEC:  rd_mux = alm_q[0];
      A_MIN:   rd_mux = cal_q.min;
      A_AMIN:  rd_mux = alm_q[1];
      A_HOUR:  rd_mux = cal_q.hour;
      A_AHOUR: rd_mux = alm_q[2];
      A_DOW:   rd_mux = cal_q.dow;
      A_DATE:  rd_mux = cal_q.date;
      A_MON:   rd_mux = cal_q.mon;
      A_YEAR:  rd_mux = cal_q.year;
      A_CTRL:  rd_mux = {4'b0, alarm_q, h24_q, bin_q, set_q};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_q     <= RST_CAL;
      alm_q     <= '0;
      set_q     <= 1'b0;
      bin_q     <= 1'b0;
      h24_q     <= 1'b1;
      alarm_q   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) rsp_data <= rd_mux;
      if (sec_tick) begin
        if (!set_q) begin
          cal_q   <= cal_nxt;
          alarm_q <= hit;
        end else begin
          alarm_q <= 1'b0;
        end
      end
      // host write lands after the advance: it wins for its own byte
      if (wr_en) begin
        case (req_addr)
          A_SEC:   cal_q.sec  <= req_wdata;
          A_ASEC:  alm_q[0]   <= req_wdata;
          A_MIN:   cal_q.min  <= req_wdata;
          A_AMIN:  alm_q[1]   <= req_wdata;
          A_HOUR:  cal_q.hour <= req_wdata;
          A_AHOUR: alm_q[2]   <= req_wdata;
          A_DOW:   cal_q.dow  <= req_wdata;
          A_DATE:  cal_q.date <= req_wdata;
          A_MON:   cal_q.mon  <= req_wdata;
          A_YEAR:  cal_q.year <= req_wdata;
          A_CTRL: begin
            set_q <= req_wdata[0];
            bin_q <= req_wdata[1];
            h24_q <= req_wdata[2];
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/rtc_calendar_core_chk.sv
module rtc_calendar_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ref_en,
  input logic       req_valid,
  input logic       req_write,
  input logic [3:0] req_addr,
  input logic       sec_tick,
  input logic       set_q,
  input logic [7:0] sec_byte,
  input logic       alarm_o,
  input logic       rsp_valid
);
  logic wr_sec;
  assign wr_sec = req_valid && req_write && (req_addr == 4'd0);

  AST_TICK_NEEDS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> ref_en); // R1
  AST_QUIET_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !wr_sec) |=> $stable(sec_byte)); // R1
  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_q && !wr_sec) |=> $stable(sec_byte)); // R3
  AST_ALARM_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(alarm_o) |-> $past(sec_tick)); // R9
  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid); // R10
  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid); // R10
endmodule

bind rtc_calendar_core rtc_calendar_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .req_valid(req_valid),
  .req_write(req_write), .req_addr(req_addr), .sec_tick(sec_tick),
  .set_q(set_q), .sec_byte(cal_q.sec), .alarm_o(alarm_o), .rsp_valid(rsp_valid)
);

// File: tb/rtc_calendar_core_bench.sv
module rtc_calendar_core_bench;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_en = 1'b0;
  logic       req_valid = 1'b0, req_write = 1'b0;
  logic [3:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       req_ready, rsp_valid, alarm_o;
  logic [7:0] rsp_data;

  int vecs = 0;
  int fails = 0;

  always #2 clk = ~clk;

  rtc_calendar_core #(.DIV(DIV)) u_rtc_calendar_core (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .alarm_o(alarm_o)
  );

  function automatic logic [7:0] benc(int v, bit bin);
    return bin ? 8'(v) : 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [7:0] bhr(int v, bit bin, bit h24);
    int r;
    if (h24) return benc(v, bin);
    r = v % 12;
    if (r == 0) r = 12;
    return benc(r, bin) | ((v >= 12) ? 8'h80 : 8'h00);
  endfunction

  function automatic int bdim(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    vecs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, got, exp);
    end
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 4'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd_chk(string tag, int a, logic [7:0] exp);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 4'(a);
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " rsp_valid"}, {7'b0, rsp_valid}, 8'h01);
    chk(tag, rsp_data, exp);
  endtask

  task automatic ticks(int n);
    repeat (n) begin
      @(negedge clk);
      ref_en = 1'b1;
    end
    @(negedge clk);
    ref_en = 1'b0;
  endtask

  task automatic load(bit bin, bit h24, int s, int m, int h, int dw, int dt,
                      int mo, int y);
    wr(10, {5'b0, h24, bin, 1'b1});
    wr(0, benc(s, bin));
    wr(2, benc(m, bin));
    wr(4, bhr(h, bin, h24));
    wr(6, benc(dw, bin));
    wr(7, benc(dt, bin));
    wr(8, benc(mo, bin));
    wr(9, benc(y, bin));
    wr(10, {5'b0, h24, bin, 1'b0});
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state, R10 ready and map
    chk("R10 ready", {7'b0, req_ready}, 8'h01);
    chk("R12 alarm", {7'b0, alarm_o}, 8'h00);
    rd_chk("R12 sec", 0, 8'h00);
    rd_chk("R12 hour", 4, 8'h00);
    rd_chk("R12 dow", 6, 8'h01);
    rd_chk("R12 date", 7, 8'h01);
    rd_chk("R12 month", 8, 8'h01);
    rd_chk("R12 year", 9, 8'h00);
    rd_chk("R12 ctrl", 10, 8'h04);
    rd_chk("R12 alarm sec", 1, 8'h00);
    wr(12, 8'h5A);
    rd_chk("R10 unmapped", 12, 8'h00);

    // R1 divider and R2 seconds/minutes in both encodings
    for (int b = 0; b < 2; b++) begin
      load(b[0], 1'b1, 0, 0, 8, 1, 10, 3, 21);
      ticks(DIV - 1);
      rd_chk("R1 before tick", 0, benc(0, b[0]));
      ticks(1);
      rd_chk("R1 after tick", 0, benc(1, b[0]));
      for (int t = 2; t <= 130; t++) begin
        ticks(DIV);
        rd_chk("R2 sec", 0, benc(t % 60, b[0]));
        rd_chk("R2 min", 2, benc(t / 60, b[0]));
      end
    end

    // R4/R5 exhaustive hour advance
    for (int b = 0; b < 2; b++)
      for (int f = 0; f < 2; f++)
        for (int v = 0; v < 24; v++) begin
          load(b[0], f[0], 59, 59, v, 3, 10, 5, 20);
          ticks(DIV);
          rd_chk(f ? "R5 hour" : "R4 hour", 4, bhr((v + 1) % 24, b[0], f[0]));
          if (v == 23) rd_chk(f ? "R5 carry" : "R4 carry", 7, benc(11, b[0]));
        end

    // R6 day of week
    for (int d = 1; d <= 7; d++) begin
      load(1'b0, 1'b1, 59, 59, 23, d, 5, 6, 10);
      ticks(DIV);
      rd_chk("R6 dow", 6, benc((d == 7) ? 1 : d + 1, 1'b0));
    end
    load(1'b0, 1'b1, 59, 59, 12, 4, 5, 6, 10);
    ticks(DIV);
    rd_chk("R6 dow noon", 6, 8'h04);

    // R7/R8 month ends
    for (int b = 0; b < 2; b++)
      for (int yi = 0; yi < 6; yi++)
        for (int mo = 1; mo <= 12; mo++) begin
          int y, dm;
          y  = (yi == 5) ? 99 : yi;
          dm = bdim(mo, y);
          load(b[0], 1'b1, 59, 59, 23, 2, dm - 1, mo, y);
          ticks(DIV);
          rd_chk("R7 last day", 7, benc(dm, b[0]));
          load(b[0], 1'b1, 59, 59, 23, 2, dm, mo, y);
          ticks(DIV);
          rd_chk("R7 roll date", 7, benc(1, b[0]));
          rd_chk("R8 month", 8, benc((mo == 12) ? 1 : mo + 1, b[0]));
          rd_chk("R8 year", 9, benc((mo == 12) ? (y + 1) % 100 : y, b[0]));
        end

    // R3 freeze with divider running
    load(1'b0, 1'b1, 5, 0, 9, 1, 1, 1, 0);
    wr(10, 8'h05);
    ticks(3 * DIV);
    rd_chk("R3 frozen", 0, 8'h05);
    ticks(DIV - 1);
    wr(10, 8'h04);
    ticks(1);
    rd_chk("R3 divider kept count", 0, 8'h06);

    // R11 write on tick edge
    load(1'b0, 1'b1, 59, 5, 10, 1, 1, 1, 0);
    ticks(DIV - 1);
    @(negedge clk);
    ref_en = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 4'd0; req_wdata = 8'h30;
    @(negedge clk);
    ref_en = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    rd_chk("R11 written byte", 0, 8'h30);
    rd_chk("R11 carry kept", 2, 8'h06);

    // R9 alarm
    wr(1, 8'h30); wr(3, 8'h20); wr(5, 8'h10);
    load(1'b0, 1'b1, 29, 20, 10, 1, 1, 1, 0);
    ticks(DIV);
    chk("R9 match", {7'b0, alarm_o}, 8'h01);
    rd_chk("R9 ctrl flag", 10, 8'h0C);
    ticks(DIV);
    chk("R9 one tick", {7'b0, alarm_o}, 8'h00);
    wr(1, 8'hC0); wr(3, 8'hFF);
    load(1'b0, 1'b1, 29, 20, 10, 1, 1, 1, 0);
    ticks(DIV);
    chk("R9 dont care a", {7'b0, alarm_o}, 8'h01);
    ticks(DIV);
    chk("R9 dont care b", {7'b0, alarm_o}, 8'h01);
    wr(10, 8'h05);
    ticks(DIV);
    chk("R9 freeze clears", {7'b0, alarm_o}, 8'h00);
    wr(3, 8'h21);
    load(1'b0, 1'b1, 29, 20, 10, 1, 1, 1, 0);
    ticks(DIV);
    chk("R9 mismatch", {7'b0, alarm_o}, 8'h00);

    finish_run();
  end
endmodule